// File: doc/BRIEF.md
# Size-Aware ALU with Condition Flags

This block is the integer arithmetic and logic stage of a 32-bit register machine. Each cycle it takes a source operand, a destination operand, an operation code and an operand size (byte, word or long). It returns the destination value after the operation and the next value of a five-bit condition flag set. Only the low 8, 16 or 32 bits chosen by the size take part in the operation. Bits above that lane are copied unchanged from the destination.

The supported operations are add, subtract, compare, bitwise AND, OR and XOR, invert, clear and move. Each operation has its own rule for which flags it writes and which it leaves alone. The flag register sits inside the block. It loads the computed flags only when the caller asserts the write enable. Because the extend flag can be carried over from the register, the next-flag output depends on both the inputs and the stored state.

Top module: `sized_alu`

## Requirements
- R1: Size code 0 selects byte (bits 7:0), 1 selects word (bits 15:0), and 2 or 3 select long (bits 31:0). Every result bit above the selected lane equals the matching destination bit.
- R2: Op 0 (add) yields dst+src in the lane. C is the carry out of the lane MSB, and X equals C. V is signed overflow: both operand signs are equal and the result sign differs. For a byte add, 0x1D+0x0E gives 0x2B.
- R3: Op 1 (subtract) yields dst-src in the lane. C is set when src is greater than dst as unsigned lane values, and X equals C. V is set when the operand signs differ and the result sign differs from the dst sign.
- R4: Op 2 (compare) sets N, Z, V and C as subtract would. The result equals dst unchanged, and X keeps its stored value.
- R5: Ops 3 (AND), 4 (OR), 5 (XOR) and 6 (invert dst) write the lane result, set N and Z from it, clear V and C, and keep X. For a byte operation, 0x1D AND 0x0E gives 0x0C and 0x1D OR 0x0E gives 0x1F.
- R6: Op 8 (move) writes the lane bits of src into dst. It sets N and Z from the moved value, clears V and C, and keeps X.
- R7: Op 7 (clear) writes zero to the lane and yields flags N=0, Z=1, V=0, C=0 with X kept.
- R8: Where an op sets N and Z, N is the MSB of the lane result and Z is 1 exactly when every lane result bit is zero.
- R9: flags_next and flags_q are ordered {X,N,Z,V,C} in bits 4..0. flags_q is 0 after reset. On a rising clock edge, flags_q loads flags_next only when flag_we is 1, and otherwise keeps its value.
- R10: Op codes 9 to 15 return dst unchanged, and flags_next equals flags_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| size | input | 2 | Operand size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| flag_we | input | 1 | Flag register write enable |
| result | output | 32 | Merged destination value |
| flags_next | output | 5 | Computed flags {X,N,Z,V,C} |
| flags_q | output | 5 | Stored flags {X,N,Z,V,C} |

## Verification
The hardest cases to reach are those where X must be kept while it holds a 1, and where carry or overflow at a narrow lane must be told apart from the same operands at long size. Random operands seldom set X to 1 and then follow it with a logic, compare or clear op. The stimulus therefore first runs directed adds and subtracts that produce a carry or borrow with the write enable set. It then issues the X-keeping ops, and it places byte and word operands at the lane sign and carry boundaries (0x7F+1, 0x00-1, 0xFFFF+1) with non-zero upper destination bits. A long random run with random write enables then covers the remaining combinations. A behavioural model that carries its own flag state is compared against the outputs on every cycle.

// File: rtl/sized_alu.sv
module sized_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] src,
  input  logic [31:0] dst,
  input  logic        flag_we,
  output logic [31:0] result,
  output logic [4:0]  flags_next,
  output logic [4:0]  flags_q
);
  localparam int XB = 4, NB = 3, ZB = 2, VB = 1, CB = 0;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_AND = 4'd3,
                         OP_OR = 4'd4, OP_XOR = 4'd5, OP_NOT = 4'd6, OP_CLR = 4'd7,
                         OP_MOV = 4'd8;

  logic [31:0] mask, a, b, r;
  logic [32:0] sum, dif;
  logic        sa, sb, sr, cy_add, brw, nz_ok;

  function automatic logic lane_msb(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[31];
    endcase
  endfunction

  assign mask = (size == 2'd0) ? 32'h0000_00FF :
                (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign a   = src & mask;
  assign b   = dst & mask;
  assign sum = {1'b0, b} + {1'b0, a};
  assign dif = {1'b0, b} - {1'b0, a};
  assign sa  = lane_msb(a, size);
  assign sb  = lane_msb(b, size);
  assign brw = a > b;
  assign cy_add = (size == 2'd0) ? sum[8] : (size == 2'd1) ? sum[16] : sum[32];

  always_comb begin
    r = b;
    case (op)
      OP_ADD:          r = sum[31:0];
      OP_SUB, OP_CMP:  r = dif[31:0];
      OP_AND:          r = a & b;
      OP_OR:           r = a | b;
      OP_XOR:          r = a ^ b;
      OP_NOT:          r = ~b;
      OP_CLR:          r = '0;
      OP_MOV:          r = a;
      default:         r = b;
    endcase
  end

  assign sr = lane_msb(r, size);

  always_comb begin
    flags_next = flags_q;
    case (op)
      OP_ADD: begin
        flags_next[CB] = cy_add;
        flags_next[XB] = cy_add;
        flags_next[VB] = (sa == sb) && (sr != sa);
      end
      OP_SUB: begin
        flags_next[CB] = brw;
        flags_next[XB] = brw;
        flags_next[VB] = (sa != sb) && (sr != sb);
      end
      OP_CMP: begin
        flags_next[CB] = brw;
        flags_next[VB] = (sa != sb) && (sr != sb);
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR, OP_MOV: begin
        flags_next[CB] = 1'b0;
        flags_next[VB] = 1'b0;
      end
      default: ;
    endcase
    nz_ok = (op <= OP_MOV);
    if (nz_ok) begin
      flags_next[NB] = sr;
      flags_next[ZB] = ((r & mask) == 32'h0);
    end
  end

  assign result = (op == OP_CMP || op > OP_MOV) ? dst : ((dst & ~mask) | (r & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= flags_next;
  end

  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    size == 2'd0 |-> result[31:8] == dst[31:8]); // R1
  AST_WORD_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    size == 2'd1 |-> result[31:16] == dst[31:16]); // R1
  AST_ADD_X_IS_C: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ADD |-> flags_next[XB] == flags_next[CB]); // R2
  AST_SUB_X_IS_C: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SUB |-> flags_next[XB] == flags_next[CB]); // R3
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CMP |-> result == dst && flags_next[XB] == flags_q[XB]); // R4
  AST_LOGIC_VC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= OP_AND && op <= OP_MOV) |-> flags_next[1:0] == 2'b00 && flags_next[XB] == flags_q[XB]); // R5
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLR |-> flags_next[3:0] == 4'b0100); // R7
  AST_BYTE_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_CMP && op <= OP_MOV && size == 2'd0) |-> flags_next[ZB] == (result[7:0] == 8'h00)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q)); // R9
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags_q == $past(flags_next)); // R9
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op > OP_MOV |-> result == dst && flags_next == flags_q); // R10
endmodule

// File: tb/sized_alu_bench.sv
module sized_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0, dst = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic [4:0]  flags_next, flags_q;
  logic [4:0]  mflags = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sized_alu u_sized_alu (.clk(clk), .rst_n(rst_n), .op(op), .size(size), .src(src),
    .dst(dst), .flag_we(flag_we), .result(result), .flags_next(flags_next), .flags_q(flags_q));

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      0: return "R2 add";
      1: return "R3 sub";
      2: return "R4 cmp";
      3, 4, 5, 6: return "R5 logic";
      7: return "R7 clr";
      8: return "R6 move";
      default: return "R10 unused op";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] s,
                       input logic [31:0] d, input logic [4:0] fq,
                       output logic [31:0] res, output logic [4:0] fl);
    int w;
    longint unsigned m, a, b, t, r;
    bit sa, sb, sr, c, v, wr, nz;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    a = s & m; b = d & m;
    fl = fq; c = 0; v = 0; wr = 1; nz = 1; r = b;
    sa = a[w-1]; sb = b[w-1];
    case (o)
      0: begin t = b + a; r = t & m; c = t[w]; v = (sa == sb) && (r[w-1] != sa); end
      1, 2: begin r = (b - a) & m; c = a > b; v = (sa != sb) && (r[w-1] != sb); end
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: r = ~b & m;
      7: r = 0;
      8: r = a;
      default: begin wr = 0; nz = 0; end
    endcase
    sr = r[w-1];
    if (o == 2) wr = 0;
    if (nz) begin fl[3] = sr; fl[2] = (r == 0); fl[1] = v; fl[0] = c; end
    if (o <= 1) fl[4] = c;
    res = wr ? ((d & ~m[31:0]) | r[31:0]) : d;
  endtask

  task automatic step(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] s,
                      input logic [31:0] d, input logic we);
    logic [31:0] er;
    logic [4:0]  ef;
    @(negedge clk);
    op = o; size = sz; src = s; dst = d; flag_we = we;
    #1;
    model(o, sz, s, d, mflags, er, ef);
    chk({req_of(o), " result"}, result, er);
    chk({req_of(o), " flags"}, flags_next, ef);
    chk("R9 stored flags", flags_q, mflags);
    if (sz != 2'd3 && sz != 2'd2) chk("R1 upper lane kept", result >> ((sz == 0) ? 8 : 16),
                                      er >> ((sz == 0) ? 8 : 16));
    if (o <= 8 && o != 2) begin
      chk("R8 N flag", flags_next[3], ef[3]);
      chk("R8 Z flag", flags_next[2], ef[2]);
    end
    @(posedge clk);
    if (we) mflags = ef;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R9 reset flags", flags_q, 0);
    rst_n = 1'b1;
    step(3, 0, 32'h1D, 32'hAB00_000E, 1);
    chk("R5 AND example", result[7:0], 8'h0C);
    step(4, 0, 32'h1D, 32'h0000_000E, 1);
    chk("R5 OR example", result[7:0], 8'h1F);
    step(0, 0, 32'h1D, 32'h0000_000E, 1);
    chk("R2 ADD example", result[7:0], 8'h2B);
    step(0, 0, 32'h01, 32'h1234_567F, 1);
    step(0, 1, 32'h0001, 32'h5555_FFFF, 1);
    step(3, 0, 32'hFF, 32'h00, 1);
    step(2, 0, 32'h01, 32'h00, 1);
    step(7, 1, 32'h0, 32'hDEAD_BEEF, 1);
    step(1, 0, 32'h01, 32'hCC00_0000, 1);
    step(6, 2, 32'h0, 32'hFFFF_FFFF, 1);
    step(8, 0, 32'h80, 32'h1111_1111, 0);
    step(9, 0, 32'h0, 32'h2222_2222, 1);
    step(15, 2, 32'hFFFF_FFFF, 32'h0, 0);
    step(0, 2, 32'h1, 32'hFFFF_FFFF, 1);
    step(1, 3, 32'h8000_0000, 32'h7FFF_FFFF, 1);
    step(5, 1, 32'h00FF, 32'hABCD_00FF, 0);
    for (int i = 0; i < 2000; i++)
      step(4'($urandom_range(0, 15)), 2'($urandom), $urandom, $urandom, 1'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule